// File: doc/BRIEF.md
# Batched complex FIR convolution engine

This block computes the full linear convolution of a complex input block with a complex tap set, for a batch of independent jobs run one after another. Each job brings its own taps and its own samples. All jobs share one flat stream of sample slots. A job occupies `K_TAPS/LOAD_W` leading slots, then `N_SAMP` data slots, then `K_TAPS-1` trailing slots. During the leading slots the tap set is written, `LOAD_W` taps per slot. The trailing slots flush the end of the convolution out of the delay line. Because the slot counter simply wraps from the last trailing slot to the first leading slot of the next job, a batch needs no control state beyond that counter.

Each accepted slot shifts a complex delay line by one place. The engine forces the sample to zero in padding slots, whatever the host drives. A two-stage pipeline then forms `K_TAPS` complex products and adds them in an accumulator that is wide enough never to overflow. The result for every data and trailing slot appears on the output with a valid strobe. A last flag marks the final result of each job.

Top module: `cfir_engine`

## Requirements
- R1: After reset, out_valid_o and out_last_o are low, and all taps and delay-line entries are zero.
- R2: A job is exactly K_TAPS/LOAD_W + N_SAMP + K_TAPS-1 accepted slots long and yields exactly N_SAMP+K_TAPS-1 results. The next job's leading slots follow at once.
- R3: In leading slot g (counted from 0), lane i of coef_re_i/coef_im_i (bits [i*DATA_W +: DATA_W]) is written to tap g*LOAD_W+i.
- R4: Taps change only in accepted leading slots. Coefficient inputs in data slots, trailing slots and idle cycles have no effect.
- R5: Sample inputs in leading and trailing slots are ignored and enter the delay line as zero.
- R6: Result n of a job equals the sum over j of C[j]·x[n-j] for 0 <= n-j < N_SAMP, with real = cr·xr − ci·xi and imag = cr·xi + ci·xr, in signed two's complement.
- R7: A result is valid in the third cycle after the cycle in which its data or trailing slot was presented. Leading slots yield no valid result.
- R8: out_last_o is high together with the valid of the last result of each job, and at no other time.
- R9: A cycle with in_valid_i low changes no state and produces no result of its own.
- R10: Full-scale inputs (−32768 and 32767 parts on both samples and taps) give the exact result, with no wrap.
- R11: Consecutive jobs in a batch are independent. A job's results do not depend on the samples or taps of the job before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Slot strobe; one slot is accepted per high cycle |
| in_re_i | input | DATA_W | Sample real part, signed |
| in_im_i | input | DATA_W | Sample imaginary part, signed |
| coef_re_i | input | LOAD_W*DATA_W | Tap real parts, one lane per tap, lane 0 lowest |
| coef_im_i | input | LOAD_W*DATA_W | Tap imaginary parts, same lane order |
| out_valid_o | output | 1 | Result strobe |
| out_last_o | output | 1 | Final result of the current job |
| out_re_o | output | 2*DATA_W+1+clog2(K_TAPS) | Result real part, signed |
| out_im_o | output | 2*DATA_W+1+clog2(K_TAPS) | Result imaginary part, signed |

## Verification
The assertions check the following on every cycle. Taps hold outside leading slots. A padding slot always leaves a zero at the newest delay-line position. An idle cycle leaves the delay line untouched. Every valid result follows an accepted slot by exactly three cycles. Each last flag closes a run of exactly N_SAMP+K_TAPS-1 results. The numeric values can only be shown by the bench's scenarios, which compare against a direct convolution. These scenarios cover back-to-back and gapped streams, junk on ignored inputs, full-scale operands and a batch of jobs with different random taps.

// File: rtl/cfir_pkg.sv
package cfir_pkg;

  typedef enum logic [1:0] {
    PH_LEAD = 2'd0,
    PH_DATA = 2'd1,
    PH_TAIL = 2'd2
  } phase_e;

  function automatic int job_slots(int n, int k, int lw);
    return k / lw + n + k - 1;
  endfunction

  function automatic int bits_for(int v);
    return (v > 1) ? $clog2(v) : 1;
  endfunction

endpackage

// File: rtl/cfir_slot_ctrl.sv
module cfir_slot_ctrl
  import cfir_pkg::*;
#(
  parameter int N_SAMP = 32,
  parameter int K_TAPS = 8,
  parameter int LOAD_W = 2,
  localparam int LOAD_SLOTS = K_TAPS / LOAD_W,
  localparam int SLOTS      = job_slots(N_SAMP, K_TAPS, LOAD_W),
  localparam int SLOT_W     = bits_for(SLOTS),
  localparam int GRP_W      = bits_for(LOAD_SLOTS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output phase_e           phase_o,
  output logic [GRP_W-1:0] grp_o,
  output logic             last_o
);

  logic [SLOT_W-1:0] slot_q;

  assign last_o = (slot_q == SLOT_W'(SLOTS - 1));
  assign grp_o  = slot_q[GRP_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
    end else if (adv_i) begin
      slot_q <= last_o ? '0 : slot_q + 1'b1;
    end
  end

  always_comb begin
    if (slot_q < SLOT_W'(LOAD_SLOTS))               phase_o = PH_LEAD;
    else if (slot_q < SLOT_W'(LOAD_SLOTS + N_SAMP)) phase_o = PH_DATA;
    else                                            phase_o = PH_TAIL;
  end

endmodule

// File: rtl/cfir_coef_bank.sv
module cfir_coef_bank
  import cfir_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int K_TAPS = 8,
  parameter int LOAD_W = 2,
  localparam int GRP_W = bits_for(K_TAPS / LOAD_W)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [GRP_W-1:0]           grp_i,
  input  logic [LOAD_W*DATA_W-1:0]   lane_re_i,
  input  logic [LOAD_W*DATA_W-1:0]   lane_im_i,
  output logic signed [DATA_W-1:0]   c_re_o [K_TAPS],
  output logic signed [DATA_W-1:0]   c_im_o [K_TAPS]
);

  logic                     wr    [K_TAPS];
  logic signed [DATA_W-1:0] nv_re [K_TAPS];
  logic signed [DATA_W-1:0] nv_im [K_TAPS];

  for (genvar k = 0; k < K_TAPS; k++) begin : g_tap
    localparam int GRP  = k / LOAD_W;
    localparam int LANE = k % LOAD_W;
    assign wr[k]    = we_i && (grp_i == GRP_W'(GRP));
    assign nv_re[k] = lane_re_i[LANE*DATA_W +: DATA_W];
    assign nv_im[k] = lane_im_i[LANE*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < K_TAPS; k++) begin
        c_re_o[k] <= '0;
        c_im_o[k] <= '0;
      end
    end else begin
      for (int k = 0; k < K_TAPS; k++) begin
        if (wr[k]) begin
          c_re_o[k] <= nv_re[k];
          c_im_o[k] <= nv_im[k];
        end
      end
    end
  end

endmodule

// File: rtl/cfir_delay_line.sv
module cfir_delay_line #(
  parameter int DATA_W = 16,
  parameter int K_TAPS = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     shift_i,
  input  logic signed [DATA_W-1:0] re_i,
  input  logic signed [DATA_W-1:0] im_i,
  output logic signed [DATA_W-1:0] d_re_o [K_TAPS],
  output logic signed [DATA_W-1:0] d_im_o [K_TAPS]
);

  // newest sample sits at index K_TAPS-1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < K_TAPS; j++) begin
        d_re_o[j] <= '0;
        d_im_o[j] <= '0;
      end
    end else if (shift_i) begin
      for (int j = 0; j < K_TAPS - 1; j++) begin
        d_re_o[j] <= d_re_o[j+1];
        d_im_o[j] <= d_im_o[j+1];
      end
      d_re_o[K_TAPS-1] <= re_i;
      d_im_o[K_TAPS-1] <= im_i;
    end
  end

endmodule

// File: rtl/cfir_mac.sv
module cfir_mac #(
  parameter int DATA_W = 16,
  parameter int K_TAPS = 8,
  localparam int P_W   = 2 * DATA_W + 1,
  localparam int ACC_W = P_W + $clog2(K_TAPS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     v_i,
  input  logic                     last_i,
  input  logic signed [DATA_W-1:0] d_re_i [K_TAPS],
  input  logic signed [DATA_W-1:0] d_im_i [K_TAPS],
  input  logic signed [DATA_W-1:0] c_re_i [K_TAPS],
  input  logic signed [DATA_W-1:0] c_im_i [K_TAPS],
  output logic                     valid_o,
  output logic                     last_o,
  output logic signed [ACC_W-1:0]  re_o,
  output logic signed [ACC_W-1:0]  im_o
);

  logic signed [P_W-1:0] mul_re [K_TAPS];
  logic signed [P_W-1:0] mul_im [K_TAPS];
  logic signed [P_W-1:0] pr_q   [K_TAPS];
  logic signed [P_W-1:0] pi_q   [K_TAPS];
  logic                  v1_q, l1_q;
  logic signed [ACC_W-1:0] sum_re, sum_im;

  // tap j pairs with delay entry K_TAPS-1-j
  for (genvar j = 0; j < K_TAPS; j++) begin : g_mul
    logic signed [P_W-1:0] xr, xi, cr, ci;
    assign xr = P_W'(d_re_i[K_TAPS-1-j]);
    assign xi = P_W'(d_im_i[K_TAPS-1-j]);
    assign cr = P_W'(c_re_i[j]);
    assign ci = P_W'(c_im_i[j]);
    assign mul_re[j] = cr * xr - ci * xi;
    assign mul_im[j] = cr * xi + ci * xr;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q <= 1'b0;
      l1_q <= 1'b0;
      for (int j = 0; j < K_TAPS; j++) begin
        pr_q[j] <= '0;
        pi_q[j] <= '0;
      end
    end else begin
      v1_q <= v_i;
      l1_q <= last_i;
      if (v_i) begin
        for (int j = 0; j < K_TAPS; j++) begin
          pr_q[j] <= mul_re[j];
          pi_q[j] <= mul_im[j];
        end
      end
    end
  end

  always_comb begin
    sum_re = '0;
    sum_im = '0;
    for (int j = 0; j < K_TAPS; j++) begin
      sum_re = sum_re + ACC_W'(pr_q[j]);
      sum_im = sum_im + ACC_W'(pi_q[j]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      last_o  <= 1'b0;
      re_o    <= '0;
      im_o    <= '0;
    end else begin
      valid_o <= v1_q;
      last_o  <= l1_q;
      if (v1_q) begin
        re_o <= sum_re;
        im_o <= sum_im;
      end
    end
  end

endmodule

// File: rtl/cfir_engine.sv
module cfir_engine
  import cfir_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int N_SAMP = 32,
  parameter int K_TAPS = 8,
  parameter int LOAD_W = 2,
  localparam int ACC_W = 2 * DATA_W + 1 + $clog2(K_TAPS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      in_valid_i,
  input  logic signed [DATA_W-1:0]  in_re_i,
  input  logic signed [DATA_W-1:0]  in_im_i,
  input  logic [LOAD_W*DATA_W-1:0]  coef_re_i,
  input  logic [LOAD_W*DATA_W-1:0]  coef_im_i,
  output logic                      out_valid_o,
  output logic                      out_last_o,
  output logic signed [ACC_W-1:0]   out_re_o,
  output logic signed [ACC_W-1:0]   out_im_o
);

  localparam int GRP_W = bits_for(K_TAPS / LOAD_W);

  if (LOAD_W < 1 || (K_TAPS % LOAD_W) != 0) begin : g_bad_cfg
    $error("K_TAPS must be a multiple of LOAD_W");
  end

  phase_e                   phase;
  logic [GRP_W-1:0]         grp;
  logic                     slot_last;
  logic                     ld_en, pad_shift;
  logic signed [DATA_W-1:0] smp_re, smp_im;
  logic signed [DATA_W-1:0] dl_re [K_TAPS];
  logic signed [DATA_W-1:0] dl_im [K_TAPS];
  logic signed [DATA_W-1:0] c_re  [K_TAPS];
  logic signed [DATA_W-1:0] c_im  [K_TAPS];
  logic                     v0_q, l0_q;

  assign ld_en     = in_valid_i && (phase == PH_LEAD);
  assign pad_shift = in_valid_i && (phase != PH_DATA);
  assign smp_re    = (phase == PH_DATA) ? in_re_i : '0;
  assign smp_im    = (phase == PH_DATA) ? in_im_i : '0;

  cfir_slot_ctrl #(
    .N_SAMP(N_SAMP), .K_TAPS(K_TAPS), .LOAD_W(LOAD_W)
  ) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (in_valid_i),
    .phase_o(phase),
    .grp_o  (grp),
    .last_o (slot_last)
  );

  cfir_coef_bank #(
    .DATA_W(DATA_W), .K_TAPS(K_TAPS), .LOAD_W(LOAD_W)
  ) u_coef (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (ld_en),
    .grp_i    (grp),
    .lane_re_i(coef_re_i),
    .lane_im_i(coef_im_i),
    .c_re_o   (c_re),
    .c_im_o   (c_im)
  );

  cfir_delay_line #(
    .DATA_W(DATA_W), .K_TAPS(K_TAPS)
  ) u_dline (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(in_valid_i),
    .re_i   (smp_re),
    .im_i   (smp_im),
    .d_re_o (dl_re),
    .d_im_o (dl_im)
  );

  // tag the accepted slot; leading slots carry no result
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v0_q <= 1'b0;
      l0_q <= 1'b0;
    end else begin
      v0_q <= in_valid_i && (phase != PH_LEAD);
      l0_q <= in_valid_i && slot_last;
    end
  end

  cfir_mac #(
    .DATA_W(DATA_W), .K_TAPS(K_TAPS)
  ) u_mac (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .v_i    (v0_q),
    .last_i (l0_q),
    .d_re_i (dl_re),
    .d_im_i (dl_im),
    .c_re_i (c_re),
    .c_im_i (c_im),
    .valid_o(out_valid_o),
    .last_o (out_last_o),
    .re_o   (out_re_o),
    .im_o   (out_im_o)
  );

endmodule

// File: rtl/cfir_engine_chk.sv
module cfir_engine_chk #(
  parameter int DATA_W = 16,
  parameter int N_SAMP = 32,
  parameter int K_TAPS = 8
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     in_valid_i,
  input logic                     out_valid_o,
  input logic                     out_last_o,
  input logic                     ld_en_i,
  input logic                     pad_shift_i,
  input logic signed [DATA_W-1:0] new_re_i,
  input logic signed [DATA_W-1:0] new_im_i,
  input logic signed [DATA_W-1:0] c_re_i [K_TAPS],
  input logic signed [DATA_W-1:0] c_im_i [K_TAPS]
);

  int out_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          out_cnt <= 0;
    else if (out_valid_o) out_cnt <= out_last_o ? 0 : out_cnt + 1;
  end

  assert_last_with_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> out_valid_o);

  assert_job_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_last_o) |-> (out_cnt == N_SAMP + K_TAPS - 2));

  assert_latency_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(in_valid_i, 3));

  assert_pad_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pad_shift_i |=> (new_re_i == '0 && new_im_i == '0));

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> ($stable(new_re_i) && $stable(new_im_i)));

  for (genvar k = 0; k < K_TAPS; k++) begin : g_hold
    assert_coef_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ld_en_i |=> ($stable(c_re_i[k]) && $stable(c_im_i[k])));
  end

endmodule

bind cfir_engine cfir_engine_chk #(
  .DATA_W(DATA_W), .N_SAMP(N_SAMP), .K_TAPS(K_TAPS)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .out_valid_o(out_valid_o),
  .out_last_o (out_last_o),
  .ld_en_i    (ld_en),
  .pad_shift_i(pad_shift),
  .new_re_i   (dl_re[K_TAPS-1]),
  .new_im_i   (dl_im[K_TAPS-1]),
  .c_re_i     (c_re),
  .c_im_i     (c_im)
);

// File: tb/tb_cfir_engine.sv
module tb_cfir_engine;
  localparam int DW    = 16;
  localparam int N     = 32;
  localparam int K     = 8;
  localparam int LW    = 2;
  localparam int LS    = K / LW;
  localparam int SLOTS = LS + N + K - 1;
  localparam int AW    = 2 * DW + 1 + $clog2(K);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic                  in_valid = 1'b0;
  logic signed [DW-1:0]  in_re = '0, in_im = '0;
  logic [LW*DW-1:0]      cf_re = '0, cf_im = '0;
  logic                  out_valid, out_last;
  logic signed [AW-1:0]  out_re, out_im;

  cfir_engine #(.DATA_W(DW), .N_SAMP(N), .K_TAPS(K), .LOAD_W(LW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid),
    .in_re_i(in_re), .in_im_i(in_im), .coef_re_i(cf_re), .coef_im_i(cf_im),
    .out_valid_o(out_valid), .out_last_o(out_last),
    .out_re_o(out_re), .out_im_o(out_im)
  );

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  int cre[K], cim[K], xre[N], xim[N];
  longint q_re[$], q_im[$];
  bit     q_last[$];
  string  q_tag[$];

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int rnd16();
    return int'($urandom_range(0, 65535)) - 32768;
  endfunction

  always @(negedge clk) begin
    longint er, ei;
    bit     el;
    string  t;
    if (rst_n) begin
      if (out_last && !out_valid) check(1'b0, "R8", "last without valid", 1, 0);
      if (out_valid) begin
        if (q_re.size() == 0) begin
          check(1'b0, "R7", "unexpected output valid", 1, 0);
        end else begin
          er = q_re.pop_front();
          ei = q_im.pop_front();
          el = q_last.pop_front();
          t  = q_tag.pop_front();
          check(longint'(out_re) == er, t, "real part", longint'(out_re), er);
          check(longint'(out_im) == ei, t, "imag part", longint'(out_im), ei);
          check(out_last == el, "R8", "last flag", longint'(out_last), longint'(el));
        end
      end
    end
  end

  task automatic expect_job(string tag);
    for (int n = 0; n < N + K - 1; n++) begin
      longint sr = 0, si = 0;
      for (int j = 0; j < K; j++) begin
        int idx = n - j;
        if (idx >= 0 && idx < N) begin
          sr += longint'(cre[j]) * xre[idx] - longint'(cim[j]) * xim[idx];
          si += longint'(cre[j]) * xim[idx] + longint'(cim[j]) * xre[idx];
        end
      end
      q_re.push_back(sr);
      q_im.push_back(si);
      q_last.push_back(n == N + K - 2);
      q_tag.push_back(tag);
    end
  endtask

  task automatic drive_slot(bit v, int r, int i, logic [LW*DW-1:0] fr, logic [LW*DW-1:0] fi);
    @(negedge clk);
    in_valid = v;
    in_re    = DW'(r);
    in_im    = DW'(i);
    cf_re    = fr;
    cf_im    = fi;
  endtask

  task automatic idle(int n);
    for (int c = 0; c < n; c++) drive_slot(1'b0, 0, 0, '0, '0);
  endtask

  task automatic rand_job();
    for (int j = 0; j < K; j++) begin cre[j] = rnd16(); cim[j] = rnd16(); end
    for (int n = 0; n < N; n++) begin xre[n] = rnd16(); xim[n] = rnd16(); end
  endtask

  // gap: idle cycles with junk; junk: garbage on ignored inputs; probe: latency check
  task automatic send_job(bit gap, bit junk, bit probe);
    for (int s = 0; s < SLOTS; s++) begin
      logic [LW*DW-1:0] lr, li;
      int sr, si;
      if (s < LS) begin
        for (int i = 0; i < LW; i++) begin
          lr[i*DW +: DW] = DW'(cre[s*LW+i]);
          li[i*DW +: DW] = DW'(cim[s*LW+i]);
        end
      end else begin
        lr = junk ? {LW{16'($urandom)}} : '0;
        li = junk ? {LW{16'($urandom)}} : '0;
      end
      if (s >= LS && s < LS + N) begin
        sr = xre[s-LS]; si = xim[s-LS];
      end else begin
        sr = junk ? rnd16() : 0; si = junk ? rnd16() : 0;
      end
      drive_slot(1'b1, sr, si, lr, li);
      if (probe && s == LS) begin
        drive_slot(1'b0, 0, 0, '0, '0);
        check(out_valid == 1'b0, "R7", "valid 1 cycle after slot", longint'(out_valid), 0);
        drive_slot(1'b0, 0, 0, '0, '0);
        check(out_valid == 1'b0, "R7", "valid 2 cycles after slot", longint'(out_valid), 0);
        drive_slot(1'b0, 0, 0, '0, '0);
        check(out_valid == 1'b1, "R7", "valid 3 cycles after slot", longint'(out_valid), 1);
      end
      if (gap && (s % 3 == 0)) begin
        for (int g = 0; g < 1 + s % 2; g++)
          drive_slot(1'b0, rnd16(), rnd16(), {LW{16'($urandom)}}, {LW{16'($urandom)}});
      end
    end
  endtask

  task automatic drain(string tag);
    for (int c = 0; c < 20 && q_re.size() != 0; c++) idle(1);
    check(q_re.size() == 0, tag, "results missing at end of job", q_re.size(), 0);
    idle(6);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    idle(4);
    check(out_valid == 1'b0, "R1", "valid in reset", longint'(out_valid), 0);
    check(out_last == 1'b0, "R1", "last in reset", longint'(out_last), 0);
    rst_n = 1'b1;
    idle(3);
    check(out_valid == 1'b0, "R1", "valid after reset", longint'(out_valid), 0);
  endtask

  task automatic t_single();
    rand_job();
    expect_job("R3 R6");
    send_job(1'b0, 1'b0, 1'b0);
    drain("R2");
  endtask

  task automatic t_junk_gaps();
    rand_job();
    expect_job("R4 R5 R9");
    send_job(1'b1, 1'b1, 1'b0);
    drain("R9");
  endtask

  task automatic t_latency();
    rand_job();
    expect_job("R7");
    send_job(1'b0, 1'b0, 1'b1);
    drain("R7");
  endtask

  task automatic t_fullscale();
    for (int j = 0; j < K; j++) begin cre[j] = -32768; cim[j] = 32767; end
    for (int n = 0; n < N; n++) begin xre[n] = -32768; xim[n] = -32768; end
    expect_job("R10");
    send_job(1'b0, 1'b0, 1'b0);
    drain("R10");
  endtask

  task automatic t_batch();
    for (int b = 0; b < 3; b++) begin
      rand_job();
      expect_job("R11");
      send_job(1'b0, b == 1, 1'b0);
    end
    drain("R2");
  endtask

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_single();
    t_junk_gaps();
    t_latency();
    t_fullscale();
    t_batch();
    t_reset();
    t_single();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule